// File: doc/BRIEF.md
# Storage Host Register File and Interrupt Aggregator

This block is the software-visible register file of a storage host controller. It has a small global area and one 128-byte register window per implemented port. It decodes 32-bit aligned word accesses. A write is taken in one clock edge. A read returns its word combinationally from the current address.

Each port keeps a sticky status word. Hardware event pulses set bits in it, and software clears bits by writing ones. A per-port enable mask selects which status bits count. Whenever any port's status or enable changes, a global pending word is rebuilt with one bit per port. That word drives a single interrupt line, and the line is gated by a global enable bit.

The block also reports a link-status word that depends on whether a device is present on the port. It holds a task-file word per port and a link-control word. A falling detect field in the link-control word asks for a port reset. A reset bit in the global control register restores the whole block to its reset state.

Top module: `hba_regfile`

## Requirements
- R1: After reset, the global control word (0x04) reads 0x80000000. The interrupt output is low. Every port status (window offset 0x10) and enable (0x14) reads 0, and every task-file word (0x20) reads 0x00000130.
- R2: The capability word (0x00) reads bit 30, bit 20, bit 18, then (slot count minus one) in bits 12:8, then (port count minus one) in bits 4:0. The ports-implemented word (0x0C) reads (1 << ports) - 1. The version word (0x10) reads 0x00010000.
- R3: A port status word ORs in the event bits presented for that port in any cycle. Writing to it clears exactly the bits written as one. An event that arrives in the same cycle as the clear wins.
- R4: A write to a port enable word stores only the bits set in 0xFDC000FF.
- R5: In the cycle after an event, or after a write to a port status or enable word, global pending bit i (at 0x08) equals the OR of port i's status AND enable.
- R6: Writing ones to the pending word (0x08) clears those bits. A cleared bit stays clear until the next port-side change from R5.
- R7: The interrupt output is high exactly when the pending word is nonzero and bit 1 of the global control word is set. It is updated in the same edge as its inputs.
- R8: A write to the global control word keeps bits 1:0 and always reads bit 31 as one. Writing bit 0 as one resets every register to its R1 value at that edge, pulses every port reset output for one cycle, and leaves bit 0 reading zero.
- R9: A port link-status word (0x28) reads 0x00000113 when that port's device-present input is high, and 0 otherwise.
- R10: A write to the link-control word (0x2C) that moves bits 3:0 from 1 to 0 pulses that port's reset output in the next cycle and restores its task-file word to 0x0130. No other change of those bits does this.
- R11: A write to the task-file word stores the low 16 bits (error in 15:8, status in 7:0). The word reads back with the upper half zero.
- R12: Port i's window starts at 0x100 + 0x80*i. Reads of windows beyond the last port, and reads of misaligned addresses, return 0. Writes to either are dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe for the word at addr |
| addr | input | ADDR_W | Byte address of the access |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for addr, combinational |
| ev_bits | input | NPORTS*32 | Per-port event type bits, 32 per port |
| dev_present | input | NPORTS | Device attached, one per port |
| irq | output | 1 | Gated interrupt request |
| port_rst | output | NPORTS | One-cycle port reset request per port |

## Verification
The pending word is state that software cannot fully rebuild. If its rebuild or its clear goes wrong, the interrupt line and a read of 0x08 disagree with the masked port status one cycle after the stimulus. The bench therefore interleaves events, mask writes and global clears, and reads the result straight away. A bad port index decode appears either as aliasing, where a write beyond the last port changes port 0, or as nonzero reads of windows that do not exist. A missed reset condition appears on the one-cycle reset pulse, which is sampled in the exact cycle it must be present and again in the cycle after.

// File: rtl/hba_pkg.sv
`timescale 1ns/1ps
package hba_pkg;
  // global area byte offsets
  localparam logic [7:0] G_CAP  = 8'h00;
  localparam logic [7:0] G_CTL  = 8'h04;
  localparam logic [7:0] G_PEND = 8'h08;
  localparam logic [7:0] G_PIMP = 8'h0C;
  localparam logic [7:0] G_VER  = 8'h10;
  // offsets inside a port window
  localparam logic [6:0] P_ISTAT = 7'h10;
  localparam logic [6:0] P_IEN   = 7'h14;
  localparam logic [6:0] P_TFD   = 7'h20;
  localparam logic [6:0] P_LSTAT = 7'h28;
  localparam logic [6:0] P_LCTL  = 7'h2C;

  localparam logic [31:0] IEN_KEEP  = 32'hFDC0_00FF;
  localparam logic [31:0] VER_VAL   = 32'h0001_0000;
  localparam logic [31:0] LSTAT_UP  = 32'h0000_0113;
  localparam logic [31:0] CAP_FIXED = 32'h4014_0000;
  localparam logic [15:0] TFD_RST   = 16'h0130;

  function automatic logic [31:0] cap_word(input int unsigned ports, input int unsigned slots);
    logic [31:0] p, s;
    p = 32'(ports - 1) & 32'h1F;
    s = 32'(slots - 1) & 32'h1F;
    return CAP_FIXED | (s << 8) | p;
  endfunction
endpackage

// File: rtl/hba_port_win.sv
`timescale 1ns/1ps
module hba_port_win
  import hba_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        ctl_rst,
  input  logic        wr,
  input  logic [4:0]  widx,
  input  logic [31:0] wdata,
  input  logic [31:0] ev,
  input  logic        present,
  output logic [31:0] rdata,
  output logic [31:0] mask,
  output logic        hit_now,
  output logic        hit_next,
  output logic        touch,
  output logic        rst_pulse
);
  logic [31:0] stat_q, stat_d, mask_q, mask_d, sctl_q, sctl_d;
  logic [15:0] tfd_q, tfd_d;
  logic        prst_q, prst_d, det_fall;
  logic [6:0]  offs;

  assign offs = {widx, 2'b00};

  always_comb begin
    stat_d   = stat_q | ev;
    mask_d   = mask_q;
    tfd_d    = tfd_q;
    sctl_d   = sctl_q;
    det_fall = 1'b0;
    touch    = |ev;
    if (wr) begin
      case (offs)
        P_ISTAT: begin
          stat_d = (stat_q & ~wdata) | ev;
          touch  = 1'b1;
        end
        P_IEN: begin
          mask_d = wdata & IEN_KEEP;
          touch  = 1'b1;
        end
        P_TFD:  tfd_d = wdata[15:0];
        P_LCTL: begin
          sctl_d   = wdata;
          det_fall = (sctl_q[3:0] == 4'd1) && (wdata[3:0] == 4'd0);
        end
        default: ;
      endcase
    end
    if (det_fall) tfd_d = TFD_RST;
    prst_d = det_fall | ctl_rst;
    if (ctl_rst) begin
      stat_d = '0;
      mask_d = '0;
      tfd_d  = TFD_RST;
      sctl_d = '0;
      touch  = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stat_q <= '0;
      mask_q <= '0;
      tfd_q  <= TFD_RST;
      sctl_q <= '0;
      prst_q <= 1'b0;
    end else begin
      stat_q <= stat_d;
      mask_q <= mask_d;
      tfd_q  <= tfd_d;
      sctl_q <= sctl_d;
      prst_q <= prst_d;
    end
  end

  always_comb begin
    case (offs)
      P_ISTAT: rdata = stat_q;
      P_IEN:   rdata = mask_q;
      P_TFD:   rdata = {16'h0, tfd_q};
      P_LSTAT: rdata = present ? LSTAT_UP : 32'h0;
      P_LCTL:  rdata = sctl_q;
      default: rdata = 32'h0;
    endcase
  end

  assign mask      = mask_q;
  assign hit_now   = |(stat_q & mask_q);
  assign hit_next  = |(stat_d & mask_d);
  assign rst_pulse = prst_q;
endmodule

// File: rtl/hba_irq_agg.sv
`timescale 1ns/1ps
module hba_irq_agg #(
  parameter int unsigned NP = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ctl_rst,
  input  logic [NP-1:0] touch,
  input  logic [NP-1:0] hit_next,
  input  logic          clr_we,
  input  logic [NP-1:0] clr_bits,
  input  logic          ie_next,
  output logic [NP-1:0] pend,
  output logic          irq
);
  logic [NP-1:0] pend_q, pend_d;
  logic          irq_q, irq_d, pend_en;

  always_comb begin
    pend_en = ctl_rst | (|touch) | clr_we;
    if (ctl_rst)      pend_d = '0;
    else if (|touch)  pend_d = hit_next;
    else if (clr_we)  pend_d = pend_q & ~clr_bits;
    else              pend_d = pend_q;
    irq_d = ie_next & (|pend_d) & ~ctl_rst;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       pend_q <= '0;
    else if (pend_en) pend_q <= pend_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_q <= 1'b0;
    else        irq_q <= irq_d;
  end

  assign pend = pend_q;
  assign irq  = irq_q;
endmodule

// File: rtl/hba_regfile.sv
`timescale 1ns/1ps
module hba_regfile
  import hba_pkg::*;
#(
  parameter int unsigned NPORTS = 4,
  parameter int unsigned SLOTS  = 32,
  parameter int unsigned ADDR_W = 12
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_en,
  input  logic [ADDR_W-1:0]    addr,
  input  logic [31:0]          wdata,
  output logic [31:0]          rdata,
  input  logic [NPORTS*32-1:0] ev_bits,
  input  logic [NPORTS-1:0]    dev_present,
  output logic                 irq,
  output logic [NPORTS-1:0]    port_rst
);
  localparam int unsigned PIDX_W = ADDR_W - 7;
  localparam logic [ADDR_W-1:0] PORT_BASE = ADDR_W'(256);
  localparam logic [31:0] CAP_VAL = cap_word(NPORTS, SLOTS);
  localparam logic [31:0] PI_VAL  = 32'((64'd1 << NPORTS) - 64'd1);

  logic              aligned, in_glob, port_ok, wr_ok, gwr;
  logic [ADDR_W-1:0] rel;
  logic [PIDX_W-1:0] pidx;
  logic              ctl_rst, ie_q, ie_d, pend_clr;
  logic [NPORTS-1:0] port_sel, touch, hit_now, hit_next, pend_q;
  logic [NPORTS*32-1:0] mask_all;
  logic [31:0]       port_rd [NPORTS];

  assign aligned = (addr[1:0] == 2'b00);
  assign in_glob = (addr < PORT_BASE);
  assign rel     = addr - PORT_BASE;
  assign pidx    = rel[ADDR_W-1:7];
  assign port_ok = !in_glob && (32'(pidx) < NPORTS);
  assign wr_ok   = wr_en && aligned;
  assign gwr     = wr_ok && in_glob;

  assign ctl_rst  = gwr && (addr[7:0] == G_CTL) && wdata[0];
  assign pend_clr = gwr && (addr[7:0] == G_PEND);

  always_comb begin
    ie_d = ie_q;
    if (ctl_rst)                        ie_d = 1'b0;
    else if (gwr && addr[7:0] == G_CTL) ie_d = wdata[1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ie_q <= 1'b0;
    else        ie_q <= ie_d;
  end

  for (genvar i = 0; i < NPORTS; i++) begin : g_port
    assign port_sel[i] = wr_ok && port_ok && (pidx == PIDX_W'(i));
    hba_port_win u_win (
      .clk      (clk),
      .rst_n    (rst_n),
      .ctl_rst  (ctl_rst),
      .wr       (port_sel[i]),
      .widx     (addr[6:2]),
      .wdata    (wdata),
      .ev       (ev_bits[i*32 +: 32]),
      .present  (dev_present[i]),
      .rdata    (port_rd[i]),
      .mask     (mask_all[i*32 +: 32]),
      .hit_now  (hit_now[i]),
      .hit_next (hit_next[i]),
      .touch    (touch[i]),
      .rst_pulse(port_rst[i])
    );
  end

  hba_irq_agg #(.NP(NPORTS)) u_agg (
    .clk     (clk),
    .rst_n   (rst_n),
    .ctl_rst (ctl_rst),
    .touch   (touch),
    .hit_next(hit_next),
    .clr_we  (pend_clr),
    .clr_bits(wdata[NPORTS-1:0]),
    .ie_next (ie_d),
    .pend    (pend_q),
    .irq     (irq)
  );

  always_comb begin
    rdata = 32'h0;
    if (aligned && in_glob) begin
      case (addr[7:0])
        G_CAP:   rdata = CAP_VAL;
        G_CTL:   rdata = {1'b1, 29'h0, ie_q, 1'b0};
        G_PEND:  rdata = 32'(pend_q);
        G_PIMP:  rdata = PI_VAL;
        G_VER:   rdata = VER_VAL;
        default: rdata = 32'h0;
      endcase
    end else if (aligned && port_ok) begin
      for (int i = 0; i < NPORTS; i++) begin
        if (pidx == PIDX_W'(i)) rdata = port_rd[i];
      end
    end
  end
endmodule

// File: rtl/hba_regfile_chk.sv
`timescale 1ns/1ps
module hba_regfile_chk
  import hba_pkg::*;
#(
  parameter int unsigned NPORTS = 4,
  parameter int unsigned ADDR_W = 12
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 wr_en,
  input logic [ADDR_W-1:0]    addr,
  input logic [31:0]          rdata,
  input logic                 irq,
  input logic [NPORTS-1:0]    port_rst,
  input logic [NPORTS-1:0]    pend_q,
  input logic                 ie_q,
  input logic [NPORTS-1:0]    hit_now,
  input logic [NPORTS*32-1:0] mask_all
);
  logic beyond;
  assign beyond = (32'(addr) >= 32'd256) && (((32'(addr) - 32'd256) >> 7) >= NPORTS);

  // R8
  ae_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (32'(addr) == 32'd4) |-> rdata[31]);

  // R12
  no_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
    beyond |-> (rdata == 32'h0));

  // R5
  pend_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((pend_q & ~$past(pend_q) & ~hit_now) == '0));

  // R7
  irq_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (ie_q && (pend_q != '0)));

  // R10
  rst_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (port_rst != '0) |-> $past(wr_en));

  for (genvar i = 0; i < NPORTS; i++) begin : g_mask
    // R4
    mask_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((mask_all[i*32 +: 32] & ~IEN_KEEP) == 32'h0));
  end
endmodule

bind hba_regfile hba_regfile_chk #(.NPORTS(NPORTS), .ADDR_W(ADDR_W)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .wr_en   (wr_en),
  .addr    (addr),
  .rdata   (rdata),
  .irq     (irq),
  .port_rst(port_rst),
  .pend_q  (pend_q),
  .ie_q    (ie_q),
  .hit_now (hit_now),
  .mask_all(mask_all)
);

// File: tb/hba_regfile_test.sv
`timescale 1ns/1ps
module hba_regfile_test;
  localparam int NP = 4;
  localparam int AW = 12;

  logic            clk, rst_n, wr_en, irq;
  logic [AW-1:0]   addr;
  logic [31:0]     wdata, rdata;
  logic [NP*32-1:0] ev_bits;
  logic [NP-1:0]   dev_present, port_rst;
  int checks = 0, errors = 0;
  bit done = 0;

  hba_regfile #(.NPORTS(NP), .SLOTS(32), .ADDR_W(AW)) uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .rdata(rdata), .ev_bits(ev_bits), .dev_present(dev_present),
    .irq(irq), .port_rst(port_rst)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  function automatic logic [AW-1:0] pa(input int p, input int off);
    return AW'(256 + 128 * p + off);
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [31:0] d);
    @(negedge clk);
    addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [AW-1:0] a, output logic [31:0] d);
    @(negedge clk);
    addr = a;
    #1 d = rdata;
  endtask

  task automatic pulse_ev(input int p, input logic [31:0] bits);
    @(negedge clk);
    ev_bits[p*32 +: 32] = bits;
    @(negedge clk);
    ev_bits = '0;
  endtask

  task automatic t_reset;
    logic [31:0] d;
    rd(12'h004, d); check("R1 ctl", d, 32'h8000_0000);
    check("R1 irq", 32'(irq), 0);
    rd(pa(1, 'h10), d); check("R1 stat", d, 0);
    rd(pa(3, 'h14), d); check("R1 ien", d, 0);
    rd(pa(2, 'h20), d); check("R1 tfd", d, 32'h130);
  endtask

  task automatic t_ident;
    logic [31:0] d;
    rd(12'h000, d); check("R2 cap", d, 32'h4014_1F03);
    rd(12'h00C, d); check("R2 pimp", d, 32'hF);
    rd(12'h010, d); check("R2 ver", d, 32'h0001_0000);
  endtask

  task automatic t_stat;
    logic [31:0] d;
    pulse_ev(1, 32'h0000_0011);
    pulse_ev(1, 32'h0000_0100);
    rd(pa(1, 'h10), d); check("R3 or", d, 32'h111);
    wr(pa(1, 'h10), 32'h0000_0010);
    rd(pa(1, 'h10), d); check("R3 w1c", d, 32'h101);
    @(negedge clk);
    addr = pa(1, 'h10); wdata = 32'h1; wr_en = 1'b1; ev_bits[32 +: 32] = 32'h1;
    @(negedge clk);
    wr_en = 1'b0; ev_bits = '0;
    rd(pa(1, 'h10), d); check("R3 ev wins", d, 32'h101);
    wr(pa(1, 'h10), 32'hFFFF_FFFF);
    rd(pa(1, 'h10), d); check("R3 clear all", d, 0);
  endtask

  task automatic t_mask;
    logic [31:0] d;
    wr(pa(3, 'h14), 32'hFFFF_FFFF);
    rd(pa(3, 'h14), d); check("R4 keep", d, 32'hFDC0_00FF);
    wr(pa(3, 'h14), 32'h0);
  endtask

  task automatic t_pend;
    logic [31:0] d;
    wr(pa(2, 'h14), 32'h1);
    pulse_ev(2, 32'h1);
    rd(12'h008, d); check("R5 pend", d, 32'h4);
    check("R7 gated off", 32'(irq), 0);
    wr(12'h004, 32'h2);
    check("R7 on", 32'(irq), 1);
    rd(12'h004, d); check("R8 ctl ie", d, 32'h8000_0002);
    pulse_ev(1, 32'h20);
    rd(12'h008, d); check("R5 unmasked ev", d, 32'h4);
    wr(12'h008, 32'h4);
    rd(12'h008, d); check("R6 clear", d, 0);
    check("R7 off after clear", 32'(irq), 0);
    rd(pa(2, 'h10), d); check("R6 port keeps", d, 32'h1);
    wr(pa(2, 'h14), 32'h1);
    rd(12'h008, d); check("R5 rebuild", d, 32'h4);
    check("R7 back on", 32'(irq), 1);
    wr(pa(2, 'h10), 32'h1);
    rd(12'h008, d); check("R5 drop", d, 0);
    check("R7 drop", 32'(irq), 0);
    wr(pa(1, 'h10), 32'hFFFF_FFFF);
  endtask

  task automatic t_ctl;
    logic [31:0] d;
    wr(pa(0, 'h14), 32'h4);
    pulse_ev(0, 32'h4);
    wr(pa(0, 'h20), 32'h55);
    check("R7 armed", 32'(irq), 1);
    wr(12'h004, 32'h3);
    check("R8 rst pulse", 32'(port_rst), 32'hF);
    check("R8 irq low", 32'(irq), 0);
    rd(12'h004, d); check("R8 ctl", d, 32'h8000_0000);
    check("R8 pulse gone", 32'(port_rst), 0);
    rd(pa(0, 'h10), d); check("R8 stat", d, 0);
    rd(pa(0, 'h14), d); check("R8 ien", d, 0);
    rd(pa(0, 'h20), d); check("R8 tfd", d, 32'h130);
    rd(12'h008, d); check("R8 pend", d, 0);
  endtask

  task automatic t_link;
    logic [31:0] d;
    dev_present = 4'b0101;
    rd(pa(0, 'h28), d); check("R9 up", d, 32'h113);
    rd(pa(1, 'h28), d); check("R9 none", d, 0);
    rd(pa(2, 'h28), d); check("R9 up2", d, 32'h113);
  endtask

  task automatic t_tfd_sctl;
    logic [31:0] d;
    wr(pa(3, 'h20), 32'hABCD_1234);
    rd(pa(3, 'h20), d); check("R11 tfd", d, 32'h1234);
    wr(pa(3, 'h2C), 32'h2);
    check("R10 no pulse 0-2", 32'(port_rst), 0);
    wr(pa(3, 'h2C), 32'h0);
    check("R10 no pulse 2-0", 32'(port_rst), 0);
    wr(pa(3, 'h2C), 32'h1);
    check("R10 no pulse 0-1", 32'(port_rst), 0);
    wr(pa(3, 'h2C), 32'h300);
    check("R10 pulse", 32'(port_rst), 32'h8);
    rd(pa(3, 'h20), d); check("R10 tfd", d, 32'h130);
    check("R10 one cycle", 32'(port_rst), 0);
    rd(pa(3, 'h2C), d); check("R10 lctl", d, 32'h300);
  endtask

  task automatic t_decode;
    logic [31:0] d;
    wr(pa(0, 'h14), 32'h1);
    wr(pa(4, 'h14), 32'h2);
    rd(pa(4, 'h14), d); check("R12 beyond read", d, 0);
    rd(pa(0, 'h14), d); check("R12 no alias", d, 32'h1);
    wr(pa(0, 'h16), 32'hFF);
    rd(pa(0, 'h14), d); check("R12 misaligned wr", d, 32'h1);
    rd(pa(0, 'h15), d); check("R12 misaligned rd", d, 0);
    wr(pa(1, 'h14), 32'h80);
    rd(pa(1, 'h14), d); check("R12 port1", d, 32'h80);
    rd(pa(0, 'h14), d); check("R12 port0 kept", d, 32'h1);
  endtask

  initial begin
    rst_n = 1'b0; wr_en = 1'b0; addr = '0; wdata = '0;
    ev_bits = '0; dev_present = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_ident();
    t_stat();
    t_mask();
    t_pend();
    t_ctl();
    t_link();
    t_tfd_sctl();
    t_decode();
    if (!done) begin
      done = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog actual=%h expected=%h", 0, 1);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule